// File: doc/BRIEF.md
# Latched Watchdog Kick Forwarder

This block drives the trigger input of an external watchdog supervisor. From reset it generates its own trigger pulses at a fixed period, so the supervisor stays serviced while the processor boots and cannot yet service it.

The processor takes over by raising an enable line and then delivering a qualifying number of service pulses on a hit line. After that the block stops its own pulses. Each further rising edge on the hit line becomes a trigger pulse of fixed, guaranteed width. The handover is latched: only a reset of the block returns control to the internal generator.

Both processor inputs pass through two-flop synchronizers, and only rising edges of the hit line are counted. A hit that arrives while a trigger pulse is still high is absorbed into that pulse. The period, the pulse width and the handover count are all parameters, given in clock cycles.

Top module: `wdt_kick_fwd`

## Requirements
- R1: While reset is asserted, and after its release until the first pulse event, the trigger output is low.
- R2: Until handover, the block emits one trigger pulse every SELF_PERIOD cycles. The first comes about SELF_PERIOD cycles after reset release.
- R3: Handover happens only after ARM_HITS (default 16) rising edges of the hit line have been counted while enable was high. The hit edges that do the qualifying produce no trigger pulse. Every later hit edge produces one.
- R4: If enable is low at any time before handover, the qualifying count restarts from zero.
- R5: Once handover has happened, lowering enable does not undo it. Hits keep being forwarded. Only reset clears the handover.
- R6: After handover, the block emits no self-generated pulses.
- R7: Every trigger pulse is high for exactly PULSE_W clock cycles.
- R8: A hit edge that arrives while a trigger pulse is high neither extends that pulse nor starts a second one.
- R9: Hit edges that arrive while enable is low never cause handover or a forwarded pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wd_en_i | input | 1 | Processor enable for watchdog control, asynchronous |
| wd_hit_i | input | 1 | Processor service pulse, asynchronous, counted on rising edges |
| wdi_o | output | 1 | Trigger output to the supervisor |

## Verification
The hardest state to reach from the ports is the boundary of the qualifying count. The count is invisible, and it can be reset silently by a brief drop of enable. The bench resets before each vector and sends bursts of hits that stop exactly at, one past and well past the threshold. It then counts the output pulses, so any count error shows up as a difference in the number of pulses. A second path drops enable partway through qualifying, and it must produce no output at all. This proves the count was cleared and did not simply pause.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
  function automatic int cnt_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wkf_sync2.sv
module wkf_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/wkf_arm_ctrl.sv
module wkf_arm_ctrl #(
  parameter int ARM_HITS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_s_i,
  input  logic hit_s_i,
  output logic armed_o,
  output logic fwd_o
);
  localparam int CW = wkf_pkg::cnt_w(ARM_HITS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(ARM_HITS);

  logic [CW-1:0] cnt_q;
  logic          armed_q, hit_d_q;
  logic          hit_rise;

  assign hit_rise = hit_s_i & ~hit_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_d_q <= 1'b0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      hit_d_q <= hit_s_i;
      if (!armed_q) begin
        if (!en_s_i)                          cnt_q <= '0;
        else if (hit_rise && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        // latch: only reset clears
        if (en_s_i && cnt_q == CNT_MAX)        armed_q <= 1'b1;
      end
    end
  end

  assign armed_o = armed_q;
  assign fwd_o   = armed_q & hit_rise;
endmodule

// File: rtl/wkf_kick_timer.sv
module wkf_kick_timer #(
  parameter int SELF_PERIOD = 6_250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  output logic tick_o
);
  localparam int TW = wkf_pkg::cnt_w(SELF_PERIOD);
  localparam logic [TW-1:0] T_LAST = TW'(SELF_PERIOD - 1);

  logic [TW-1:0] t_q;

  assign tick_o = ~stop_i & (t_q == T_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               t_q <= '0;
    else if (stop_i || tick_o) t_q <= '0;
    else                       t_q <= t_q + 1'b1;
  end
endmodule

// File: rtl/wkf_pulse_shaper.sv
module wkf_pulse_shaper #(
  parameter int PULSE_W = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int WW = wkf_pkg::cnt_w(PULSE_W);
  localparam logic [WW-1:0] W_LOAD = WW'(PULSE_W - 1);

  logic [WW-1:0] w_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      w_q    <= '0;
    end else if (busy_q) begin
      // triggers while busy are merged (dropped)
      if (w_q == '0) busy_q <= 1'b0;
      else           w_q    <= w_q - 1'b1;
    end else if (trig_i) begin
      busy_q <= 1'b1;
      w_q    <= W_LOAD;
    end
  end

  assign pulse_o = busy_q;
endmodule

// File: rtl/wdt_kick_fwd.sv
module wdt_kick_fwd #(
  parameter int SELF_PERIOD = 6_250_000,
  parameter int PULSE_W     = 25,
  parameter int ARM_HITS    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wd_en_i,
  input  logic wd_hit_i,
  output logic wdi_o
);
  logic [1:0] sync_q;
  logic       armed, fwd, tick;

  wkf_sync2 #(.WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wd_en_i, wd_hit_i}),
    .q_o   (sync_q)
  );

  wkf_arm_ctrl #(.ARM_HITS(ARM_HITS)) u_arm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_s_i (sync_q[1]),
    .hit_s_i(sync_q[0]),
    .armed_o(armed),
    .fwd_o  (fwd)
  );

  wkf_kick_timer #(.SELF_PERIOD(SELF_PERIOD)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stop_i(armed),
    .tick_o(tick)
  );

  wkf_pulse_shaper #(.PULSE_W(PULSE_W)) u_shape (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (tick | fwd),
    .pulse_o(wdi_o)
  );
endmodule

// File: rtl/wdt_kick_fwd_chk.sv
module wkf_arm_chk #(
  parameter int ARM_HITS = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_s_i,
  input logic armed_q,
  input logic [wkf_pkg::cnt_w(ARM_HITS + 1)-1:0] cnt_q
);
  assert_armed_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> armed_q);
  assert_arm_needs_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> ($past(cnt_q) == ARM_HITS) && $past(en_s_i));
  assert_count_cleared_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !en_s_i) |=> cnt_q == '0);
endmodule

module wdt_kick_fwd_chk #(
  parameter int SELF_PERIOD = 6_250_000,
  parameter int PULSE_W     = 25
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wdi_o,
  input logic armed_i
);
  int   hi_cnt, since;
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= 0;
      since  <= 0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= wdi_o;
      hi_cnt <= wdi_o ? hi_cnt + 1 : 0;
      if (wdi_o && !prev_q)          since <= 0;
      else if (since < SELF_PERIOD + 8) since <= since + 1;
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !wdi_o);
  assert_pulse_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdi_o) |-> hi_cnt == PULSE_W);
  assert_pulse_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdi_o |-> hi_cnt < PULSE_W);
  assert_kick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> since < SELF_PERIOD + 3);
endmodule

bind wkf_arm_ctrl wkf_arm_chk #(.ARM_HITS(ARM_HITS)) u_arm_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_s_i (en_s_i),
  .armed_q(armed_q),
  .cnt_q  (cnt_q)
);

bind wdt_kick_fwd wdt_kick_fwd_chk #(.SELF_PERIOD(SELF_PERIOD), .PULSE_W(PULSE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wdi_o  (wdi_o),
  .armed_i(armed)
);

// File: tb/tb_wdt_kick_fwd.sv
module tb_wdt_kick_fwd;
  localparam int SP = 1000;
  localparam int PW = 10;
  localparam int AH = 16;
  localparam int NV = 5;
  // {enable, hits, expected output pulses}
  localparam int VEC [NV][3] = '{
    '{0, 20, 0},
    '{1, 16, 0},
    '{1, 17, 1},
    '{1, 20, 4},
    '{1, 40, 24}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic wd_en_i = 1'b0;
  logic wd_hit_i = 1'b0;
  logic wdi_o;
  int checks = 0, fails = 0;
  int rises = 0, cyc = 0, last_rise = 0, prev_rise = 0;
  int wcnt = 0, wmin = 1000000, wmax = 0;
  logic prev_o = 1'b0;
  logic done = 1'b0;

  always #5 clk_i = ~clk_i;

  wdt_kick_fwd #(.SELF_PERIOD(SP), .PULSE_W(PW), .ARM_HITS(AH)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wd_en_i(wd_en_i), .wd_hit_i(wd_hit_i), .wdi_o(wdi_o)
  );

  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    prev_o <= wdi_o;
    if (wdi_o && !prev_o) begin
      rises <= rises + 1;
      prev_rise <= last_rise;
      last_rise <= cyc;
    end
    if (wdi_o) wcnt <= wcnt + 1;
    else begin
      if (prev_o) begin
        if (wcnt < wmin) wmin <= wcnt;
        if (wcnt > wmax) wmax <= wcnt;
      end
      wcnt <= 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    wd_en_i = 1'b0;
    wd_hit_i = 1'b0;
    rst_ni = 1'b0;
    wait_n(3);
    chk("R1 low in reset", int'(wdi_o), 0);
    rst_ni = 1'b1;
    wait_n(2);
  endtask

  task automatic send_hits(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      wd_hit_i = 1'b1;
      wait_n(hi);
      wd_hit_i = 1'b0;
      wait_n(lo);
    end
  endtask

  task automatic arm();
    wd_en_i = 1'b1;
    wait_n(5);
    send_hits(AH + 1, 4, 8);
    wait_n(20);
  endtask

  initial begin
    #2 rst_ni = 1'b0;
    #30;
    // R1: reset state and quiet after release
    do_reset();
    wait_n(50);
    chk("R1 low after reset", int'(wdi_o), 0);
    chk("R1 no pulse after reset", rises, 0);

    // vectors: R3 threshold, R9 enable low
    for (int v = 0; v < NV; v++) begin
      int r0;
      do_reset();
      wd_en_i = VEC[v][0] != 0;
      wait_n(5);
      r0 = rises;
      send_hits(VEC[v][1], 4, 8);
      wait_n(30);
      chk(VEC[v][0] != 0 ? "R3 qualified hits" : "R9 hits with enable low",
          rises - r0, VEC[v][2]);
    end

    // R2: self-kick before handover
    begin
      int r0;
      do_reset();
      r0 = rises;
      wait_n(2500);
      chk("R2 self kick count", rises - r0, 2);
      chk("R2 self kick period", last_rise - prev_rise, SP);
    end

    // R4: enable drop clears the count
    begin
      int r0;
      do_reset();
      r0 = rises;
      wd_en_i = 1'b1;
      wait_n(5);
      send_hits(10, 4, 8);
      wd_en_i = 1'b0;
      wait_n(10);
      wd_en_i = 1'b1;
      wait_n(5);
      send_hits(10, 4, 8);
      wait_n(30);
      chk("R4 count restart", rises - r0, 0);
    end

    // R5/R6/R8: latched handover
    begin
      int r0;
      do_reset();
      arm();
      wd_en_i = 1'b0;
      wait_n(10);
      r0 = rises;
      send_hits(3, 4, 8);
      wait_n(30);
      chk("R5 forward with enable low", rises - r0, 3);
      r0 = rises;
      send_hits(3, 1, 2);
      wait_n(30);
      chk("R8 merged hits", rises - r0, 1);
      r0 = rises;
      wait_n(2500);
      chk("R6 no self kick after handover", rises - r0, 0);
      do_reset();
      wd_en_i = 1'b1;
      wait_n(5);
      r0 = rises;
      send_hits(5, 4, 8);
      wait_n(30);
      chk("R5 reset clears handover", rises - r0, 0);
    end

    // R7/R8: width of every pulse seen
    chk("R7 min pulse width", wmin, PW);
    chk("R8 max pulse width", wmax, PW);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule